// File: doc/BRIEF.md
# Interlace-Capable Scan Timing Generator

This block produces the raster timing for one display channel on the pixel clock. It emits horizontal sync, vertical sync, a data-enable window, a one-cycle frame-start pulse, the current field number and a frame interrupt. Software programs the timing through a simple write port. Each horizontal and vertical quantity is stored as its real count minus one.

In progressive scan every field is a full frame and uses the first vertical set. In interlaced scan the generator alternates between two fields. Each field carries half the frame height. The second field has its own vertical set, which software normally programs with a back porch one line longer than the first field's. Sync polarity, the scan mode, the run bit and the interrupt mask all sit in one control word.

Top module: `scan_timing_gen`

## Requirements
- R1: Horizontal timing is stored minus one. Write address 1 holds the active width minus one in bits [CW-1:0]. Address 2 holds three minus-one fields: sync in [CW-1:0], back porch in [2CW-1:CW] and front porch in [3CW-1:2CW]. Every line runs sync, then back porch, then active, then front porch, and the horizontal sync is asserted exactly during the sync pixels.
- R2: Vertical timing is stored minus one. Address 3 holds the per-field active height minus one. Address 4 holds the first vertical set, with the same field layout as address 2. Each field runs sync lines, back porch lines, active lines and front porch lines, and the vertical sync is asserted for every pixel of the sync lines.
- R3: Data-enable is high only when the pixel lies in the horizontal active region and the line lies in the vertical active region.
- R4: Control word (address 0) bits: 0 run, 1 hsync active-low, 2 vsync active-low, 3 interlace select, 4 field-scan enable, 5 interrupt mask. Interlaced scan requires both bit 3 and bit 4. With either bit clear the scan is progressive: every field uses the first vertical set and the field output stays 0.
- R5: In interlaced scan the field output toggles at the end of every field, so fields alternate 0, 1, 0. Field 1 uses the second vertical set at address 5.
- R6: A polarity bit of 1 makes the matching sync active-low. The inactive level is the opposite of the active level.
- R7: While the run bit is 0 both counters are held at zero, data-enable and frame-start are low, and both syncs sit at their inactive level. Setting the run bit again restarts at the first sync pixel of field 0.
- R8: The frame-start output is high for one clock, at the first pixel of the first active line of each field.
- R9: On a frame-start with the mask bit set, the interrupt status is set on the next clock. The irq output shows this status. With the mask bit clear, frame-start leaves the status unchanged.
- R10: Writing 1 to bit 0 of address 6 clears the interrupt status. Writing 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 3*CW | Register write data |
| hSync | output | 1 | Horizontal sync, polarity per control |
| vSync | output | 1 | Vertical sync, polarity per control |
| de | output | 1 | Data-enable window |
| frameStart | output | 1 | One-cycle pulse at the first active line of a field |
| fieldId | output | 1 | Current field, 0 or 1 |
| irq | output | 1 | Frame interrupt status |

## Verification
A wrong horizontal count or region bound moves the sync or data-enable edges within the first line after the run bit is set, so a per-cycle comparison against a computed raster catches it within tens of cycles. A wrong field toggle or a wrong choice of vertical set appears at the first field boundary, as a frame-start or data-enable window shifted by one line. Interrupt set and clear errors appear one clock after the frame-start pulse or after the clearing write.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // Strobes from control to the counting datapath
  typedef struct packed {
    logic run;
    logic secondSet;
  } tgStrobe_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_HACT   = 3'd1;
  localparam logic [2:0] ADDR_HPORCH = 3'd2;
  localparam logic [2:0] ADDR_VACT   = 3'd3;
  localparam logic [2:0] ADDR_VSET1  = 3'd4;
  localparam logic [2:0] ADDR_VSET2  = 3'd5;
  localparam logic [2:0] ADDR_STAT   = 3'd6;
endpackage

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
#(
  parameter int CW = 10,
  localparam int DW = 3 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          fieldEnd,
  input  logic          frameStart,
  output tgStrobe_t     strb,
  output logic [CW-1:0] hAct,
  output logic [CW-1:0] hSw,
  output logic [CW-1:0] hBp,
  output logic [CW-1:0] hFp,
  output logic [CW-1:0] vAct,
  output logic [DW-1:0] vSet1,
  output logic [DW-1:0] vSet2,
  output logic          hPolLow,
  output logic          vPolLow,
  output logic          fieldId,
  output logic          irq
);
  logic [5:0] ctrlReg;
  logic       irqStat;
  logic       interlaced;
  logic       statClr;

  assign interlaced = ctrlReg[3] & ctrlReg[4];
  assign statClr    = wrEn && (wrAddr == ADDR_STAT) && wrData[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      hAct    <= '0;
      hSw     <= '0;
      hBp     <= '0;
      hFp     <= '0;
      vAct    <= '0;
      vSet1   <= '0;
      vSet2   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL:   ctrlReg <= wrData[5:0];
        ADDR_HACT:   hAct    <= wrData[CW-1:0];
        ADDR_HPORCH: begin
          hSw <= wrData[CW-1:0];
          hBp <= wrData[2*CW-1:CW];
          hFp <= wrData[3*CW-1:2*CW];
        end
        ADDR_VACT:   vAct  <= wrData[CW-1:0];
        ADDR_VSET1:  vSet1 <= wrData;
        ADDR_VSET2:  vSet2 <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fieldId <= 1'b0;
    else if (!ctrlReg[0] || !interlaced) fieldId <= 1'b0;
    else if (fieldEnd)               fieldId <= ~fieldId;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         irqStat <= 1'b0;
    else if (frameStart && ctrlReg[5])  irqStat <= 1'b1;
    else if (statClr)                   irqStat <= 1'b0;
  end

  assign strb.run       = ctrlReg[0];
  assign strb.secondSet = interlaced & fieldId;
  assign hPolLow        = ctrlReg[1];
  assign vPolLow        = ctrlReg[2];
  assign irq            = irqStat;

  // R5
  fieldToggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && interlaced && fieldEnd && !wrEn) |=> (fieldId != $past(fieldId)));
  // R9
  irqSet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && ctrlReg[5]) |=> irqStat);
  // R10
  irqClr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statClr && !(frameStart && ctrlReg[5])) |=> !irqStat);
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
#(
  parameter int CW = 10,
  localparam int DW  = 3 * CW,
  localparam int CNT = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tgStrobe_t     strb,
  input  logic [CW-1:0] hAct,
  input  logic [CW-1:0] hSw,
  input  logic [CW-1:0] hBp,
  input  logic [CW-1:0] hFp,
  input  logic [CW-1:0] vAct,
  input  logic [DW-1:0] vSet1,
  input  logic [DW-1:0] vSet2,
  input  logic          hPolLow,
  input  logic          vPolLow,
  output logic          hSync,
  output logic          vSync,
  output logic          de,
  output logic          frameStart,
  output logic          fieldEnd
);
  logic [CNT-1:0] hCnt, vCnt;
  logic [CNT-1:0] hActStart, hActEnd, hLast;
  logic [CNT-1:0] vActStart, vActEnd, vLast;
  logic [DW-1:0]  vSel;
  logic [CW-1:0]  vSw, vBp, vFp;
  logic           hSyncAct, vSyncAct, lineEnd;

  always_comb begin
    vSel = strb.secondSet ? vSet2 : vSet1;
    vSw  = vSel[CW-1:0];
    vBp  = vSel[2*CW-1:CW];
    vFp  = vSel[3*CW-1:2*CW];

    hActStart = CNT'(hSw) + CNT'(hBp) + CNT'(2);
    hActEnd   = hActStart + CNT'(hAct);
    hLast     = hActEnd + CNT'(hFp) + CNT'(1);
    vActStart = CNT'(vSw) + CNT'(vBp) + CNT'(2);
    vActEnd   = vActStart + CNT'(vAct);
    vLast     = vActEnd + CNT'(vFp) + CNT'(1);

    hSyncAct   = strb.run && (hCnt <= CNT'(hSw));
    vSyncAct   = strb.run && (vCnt <= CNT'(vSw));
    de         = strb.run && (hCnt >= hActStart) && (hCnt <= hActEnd)
                          && (vCnt >= vActStart) && (vCnt <= vActEnd);
    frameStart = strb.run && (hCnt == '0) && (vCnt == vActStart);
    lineEnd    = strb.run && (hCnt == hLast);
    fieldEnd   = lineEnd && (vCnt == vLast);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strb.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= fieldEnd ? '0 : vCnt + CNT'(1);
    end else begin
      hCnt <= hCnt + CNT'(1);
    end
  end

  assign hSync = hSyncAct ^ hPolLow;
  assign vSync = vSyncAct ^ vPolLow;

  // R7
  idleZero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.run |=> (hCnt == '0 && vCnt == '0));
  // R3
  deSync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hSyncAct && !vSyncAct));
  // R8
  fsSingle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> !frameStart);
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import tg_pkg::*;
#(
  parameter int CW = 10,
  localparam int DW = 3 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          hSync,
  output logic          vSync,
  output logic          de,
  output logic          frameStart,
  output logic          fieldId,
  output logic          irq
);
  tgStrobe_t     strb;
  logic [CW-1:0] hAct, hSw, hBp, hFp, vAct;
  logic [DW-1:0] vSet1, vSet2;
  logic          hPolLow, vPolLow, fieldEnd;

  tg_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fieldEnd(fieldEnd), .frameStart(frameStart), .strb(strb),
    .hAct(hAct), .hSw(hSw), .hBp(hBp), .hFp(hFp), .vAct(vAct),
    .vSet1(vSet1), .vSet2(vSet2), .hPolLow(hPolLow), .vPolLow(vPolLow),
    .fieldId(fieldId), .irq(irq)
  );

  tg_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hAct(hAct), .hSw(hSw), .hBp(hBp), .hFp(hFp), .vAct(vAct),
    .vSet1(vSet1), .vSet2(vSet2), .hPolLow(hPolLow), .vPolLow(vPolLow),
    .hSync(hSync), .vSync(vSync), .de(de), .frameStart(frameStart),
    .fieldEnd(fieldEnd)
  );
endmodule

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int DW = 3 * CW;
  // Raster used throughout: 15 pixels per line; field 0 has 8 lines, field 1 has 9
  localparam int HT = 15;
  localparam int F0 = 8 * HT;
  localparam int F1 = 9 * HT;

  logic clk = 0, rst_n = 0, wrEn = 0;
  logic [2:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic hSync, vSync, de, frameStart, fieldId, irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_timing_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSync(hSync), .vSync(vSync), .de(de), .frameStart(frameStart),
    .fieldId(fieldId), .irq(irq)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
  endtask

  // Compares every cycle to a raster computed from the requirements; t=0 is
  // the negedge right after the run bit was written.
  task automatic runWindow(input int cycles, input bit inter, input bit hLow,
                           input bit vLow, input int expDe, input string tag);
    int deCount = 0;
    bit bad = 0;
    for (int t = 0; t < cycles; t++) begin
      int u, f, line, px, vs;
      bit eh, ev, ede, efs;
      if (t > 0) @(negedge clk);
      if (inter) begin
        u = t % (F0 + F1);
        f = (u >= F0) ? 1 : 0;
        if (f == 1) u = u - F0;
      end else begin
        f = 0;
        u = t % F0;
      end
      line = u / HT; px = u % HT;
      vs   = (f == 1) ? 4 : 3;
      eh   = (px <= 1) ^ hLow;
      ev   = (line == 0) ^ vLow;
      ede  = (px >= 5) && (px <= 12) && (line >= vs) && (line <= vs + 3);
      efs  = (px == 0) && (line == vs);
      if (de) deCount++;
      if (!bad && (hSync !== eh || vSync !== ev || de !== ede ||
                   frameStart !== efs || fieldId !== f[0])) begin
        bad = 1;
        $display("FAIL %s t=%0d h/v/de/fs/fld actual %b%b%b%b%b expected %b%b%b%b%b",
                 tag, t, hSync, vSync, de, frameStart, fieldId,
                 eh, ev, ede, efs, f[0]);
      end
    end
    checks++;
    if (bad) fails++;
    check(deCount == expDe,
          $sformatf("%s de count actual %0d expected %0d", tag, deCount, expDe));
  endtask

  task automatic stopRun(input logic [5:0] ctrl, input bit hLow, input bit vLow, input string tag);
    wr(3'd0, DW'(ctrl));
    check(hSync === hLow && vSync === vLow && de === 0 && frameStart === 0,
          $sformatf("%s idle actual h=%b v=%b de=%b fs=%b expected %b %b 0 0",
                    tag, hSync, vSync, de, frameStart, hLow, vLow));
    @(negedge clk); @(negedge clk);
  endtask

  task automatic testReset();
    // R7 idle levels after reset, R9 no interrupt
    check(hSync === 0 && vSync === 0 && de === 0 && frameStart === 0 && fieldId === 0,
          $sformatf("R7 reset outputs actual %b%b%b%b%b expected 00000",
                    hSync, vSync, de, frameStart, fieldId));
    check(irq === 0, $sformatf("R9 reset irq actual %b expected 0", irq));
  endtask

  task automatic testProgressive();
    // R1 R2 R3 R8: two progressive fields, 32 DE pixels each
    wr(3'd0, DW'(6'b000001));
    runWindow(2 * F0, 0, 0, 0, 64, "R1 R2 R3 R8 progressive");
    stopRun(6'b0, 0, 0, "R7 stop after progressive");
  endtask

  task automatic testInterlaced();
    // R5 R4: both bits set -> alternating fields, second has longer back porch
    wr(3'd0, DW'(6'b011001));
    runWindow(2 * (F0 + F1), 1, 0, 0, 128, "R5 interlaced");
    stopRun(6'b0, 0, 0, "R7 stop after interlaced");
  endtask

  task automatic testOneBit();
    // R4: only interlace select, or only scan enable -> progressive
    wr(3'd0, DW'(6'b001001));
    runWindow(F0 + F1, 0, 0, 0, 64, "R4 select bit only");
    stopRun(6'b0, 0, 0, "R7 stop select-only");
    wr(3'd0, DW'(6'b010001));
    runWindow(F0 + F1, 0, 0, 0, 64, "R4 enable bit only");
    stopRun(6'b0, 0, 0, "R7 stop enable-only");
  endtask

  task automatic testPolarity();
    // R6: both syncs active-low; idle level high while stopped
    wr(3'd0, DW'(6'b000110));
    check(hSync === 1 && vSync === 1,
          $sformatf("R6 idle active-low actual h=%b v=%b expected 1 1", hSync, vSync));
    wr(3'd0, DW'(6'b000111));
    runWindow(F0, 0, 1, 1, 32, "R6 active-low");
    stopRun(6'b000110, 1, 1, "R7 stop active-low");
    // R6: hsync low only
    wr(3'd0, DW'(6'b000011));
    runWindow(F0, 0, 1, 0, 32, "R6 hsync low only");
    stopRun(6'b0, 0, 0, "R7 stop hsync-low");
  endtask

  task automatic waitFs(output bit seen);
    seen = 0;
    for (int i = 0; i < 2 * F0 && !seen; i++) begin
      @(negedge clk);
      if (frameStart) seen = 1;
    end
  endtask

  task automatic testIrq();
    bit seen;
    // R9 mask clear: frame start leaves irq low
    wr(3'd0, DW'(6'b000001));
    waitFs(seen);
    @(negedge clk);
    check(seen && irq === 0, $sformatf("R9 masked irq actual %b expected 0", irq));
    // R9 mask set: irq rises one clock after frame start
    wr(3'd0, DW'(6'b100001));
    waitFs(seen);
    check(irq === 0, $sformatf("R9 irq before set actual %b expected 0", irq));
    @(negedge clk);
    check(seen && irq === 1, $sformatf("R9 irq after frame start actual %b expected 1", irq));
    check(frameStart === 0, $sformatf("R8 frame start width actual %b expected 0", frameStart));
    // R10 writing 0 keeps status, writing 1 clears it
    wr(3'd6, DW'(0));
    check(irq === 1, $sformatf("R10 write zero actual %b expected 1", irq));
    wr(3'd6, DW'(1));
    check(irq === 0, $sformatf("R10 write one actual %b expected 0", irq));
    // R9 next field sets it again
    waitFs(seen);
    @(negedge clk);
    check(seen && irq === 1, $sformatf("R9 second set actual %b expected 1", irq));
    wr(3'd6, DW'(1));
    // R7 stop mid-field then restart from the first sync pixel
    stopRun(6'b100000, 0, 0, "R7 stop mid-field");
    wr(3'd0, DW'(6'b000001));
    runWindow(F0, 0, 0, 0, 32, "R7 restart");
    stopRun(6'b0, 0, 0, "R7 final stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    // R1 horizontal: sync 2, back 3, active 8, front 2 (stored minus one)
    wr(3'd1, DW'(7));
    wr(3'd2, DW'(1) | (DW'(2) << CW) | (DW'(1) << (2 * CW)));
    // R2 vertical: active 4 lines per field; set one sync 1, back 2, front 1
    wr(3'd3, DW'(3));
    wr(3'd4, DW'(0) | (DW'(1) << CW));
    // R5 set two: back porch one line longer
    wr(3'd5, DW'(0) | (DW'(2) << CW));
    testProgressive();
    testInterlaced();
    testOneBit();
    testPolarity();
    testIrq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule